// File: doc/BRIEF.md
# SMRAM Window Control and Access Router

This block holds the host bridge's 8-bit control register for the system-management memory window and routes every memory access that falls in the legacy window at 0xA0000 to 0xBFFFF. An access goes either to DRAM or is forwarded to PCI. Software reaches the register through a small configuration port at one fixed offset.

For each access the caller presents a physical address, a flag that marks instruction fetches, and a flag that says the CPU is in system-management mode. The routing answer depends only on these inputs and on the stored register bits, so it is available in the same cycle. A lock bit, once set, stays set until the power-on reset; a separate synchronous soft reset turns decoding off but keeps the lock. A write that asks for the window to be both opened and closed is refused, and an error pulse reports it.

Register bits as the block stores them: bit 6 opens the window, bit 5 closes it to data accesses, bit 4 locks, bit 3 enables decoding, bits 2:0 always read 3'b010, and bit 7 always reads 0.

Top module: `smram_ctrl`

## Requirements
- R1: After power-on reset (rst_ni low) the register reads 8'h02 and cfg_err_o is 0. Reads at any offset other than CFG_OFFSET return 8'h00.
- R2: A write at CFG_OFFSET stores (wdata & 8'h78) | 8'h02 on the next clock edge, unless R3 or R5 modify it. A write at any other offset leaves the register unchanged.
- R3: When the stored lock bit (bit 4) is 1, a write stores bit 6 as 0 and bit 4 as 1. The other bits follow R2.
- R4: When soft_rst_i is high at a clock edge, the register becomes 8'h02 with bit 4 kept at its old value. The soft reset takes priority over a write in the same cycle. Only rst_ni clears bit 4.
- R5: A write while the register is unlocked, with wdata bits 6 and 5 both 1, is refused and the register is unchanged. cfg_err_o is 1 for exactly the cycle after that edge and 0 otherwise. A soft reset in the same cycle suppresses both the write and the error.
- R6: The window is every address whose bits 31:17 match those of 32'h000A0000. acc_dram_o=1 means DRAM and 0 means PCI. Every address outside the window routes to DRAM.
- R7: Inside the window with the enable bit (bit 3) at 0, every access routes to PCI.
- R8: Inside the window with enable=1, open=1 and lock=0, both code and data accesses route to DRAM whatever acc_smm_i is.
- R9: Inside the window with enable=1, the open bit not in effect and acc_smm_i=1, code accesses route to DRAM. Data accesses route to DRAM when closed (bit 5) is 0 and to PCI when it is 1.
- R10: Inside the window with enable=1, acc_smm_i=0 and either open=0 or lock=1, every access routes to PCI. A stored open bit has no effect while lock is 1.
- R11: acc_dram_o is combinational from the access inputs and the stored register, with no added cycle. A register change affects routing from the cycle after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst_i | input | 1 | Synchronous soft reset, keeps the lock bit |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data, combinational |
| cfg_err_o | output | 1 | Pulse for a refused open-and-closed write |
| acc_addr_i | input | 32 | Physical address of the access |
| acc_code_i | input | 1 | 1 for an instruction fetch, 0 for data |
| acc_smm_i | input | 1 | CPU is in system-management mode |
| acc_dram_o | output | 1 | 1 routes the access to DRAM, 0 to PCI |

## Verification
Routing and read data are due in the same cycle as the access or offset that produces them. The bench drives each cycle's inputs at the falling edge and compares shortly after, against a model register that has not yet taken the rising edge. Register updates and the error pulse are due one edge later. The bench applies the model update at the rising edge and samples cfg_err_o just after it, so the pulse is checked in the cycle it must appear and in every other cycle it must not.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int CFG_W = 8;

  typedef struct packed {
    logic       rsvd;
    logic       open_win;
    logic       closed;
    logic       lock;
    logic       enable;
    logic [2:0] seg;
  } smram_ctl_t;

  localparam logic [CFG_W-1:0] CTL_KEEP_MASK = 8'h78;
  localparam logic [CFG_W-1:0] CTL_FIXED     = 8'h02;
  localparam logic [CFG_W-1:0] CTL_RESET     = 8'h02;
  localparam int BIT_OPEN   = 6;
  localparam int BIT_CLOSED = 5;
  localparam int BIT_LOCK   = 4;
  localparam int BIT_EN     = 3;
endpackage

// File: rtl/smram_cfg_reg.sv
module smram_cfg_reg
  import smram_pkg::*;
#(
  parameter int               CFG_AW     = 8,
  parameter logic [CFG_AW-1:0] CFG_OFFSET = 8'h72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  output logic              cfg_err_o,
  output smram_ctl_t        ctl_o
);
  smram_ctl_t ctl_q, ctl_wr, ctl_soft;
  logic       hit, illegal, err_q;

  assign hit = cfg_we_i && (cfg_addr_i == CFG_OFFSET);

  // lock forces open low and keeps itself set
  always_comb begin
    ctl_wr = smram_ctl_t'((cfg_wdata_i & CTL_KEEP_MASK) | CTL_FIXED);
    if (ctl_q.lock) begin
      ctl_wr.open_win = 1'b0;
      ctl_wr.lock     = 1'b1;
    end
  end

  assign illegal = ctl_wr.open_win && ctl_wr.closed;

  always_comb begin
    ctl_soft      = smram_ctl_t'(CTL_RESET);
    ctl_soft.lock = ctl_q.lock;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= smram_ctl_t'(CTL_RESET);
      err_q <= 1'b0;
    end else if (soft_rst_i) begin
      ctl_q <= ctl_soft;
      err_q <= 1'b0;
    end else begin
      err_q <= hit && illegal;
      if (hit && !illegal) ctl_q <= ctl_wr;
    end
  end

  assign cfg_rdata_o = (cfg_addr_i == CFG_OFFSET) ? ctl_q : '0;
  assign cfg_err_o   = err_q;
  assign ctl_o       = ctl_q;
endmodule

// File: rtl/smram_win_match.sv
module smram_win_match #(
  parameter int              ADDR_W   = 32,
  parameter int              WIN_LSB  = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] CMP_MASK = ~((ADDR_W'(1) << WIN_LSB) - ADDR_W'(1));

  assign hit_o = ((addr_i ^ WIN_BASE) & CMP_MASK) == '0;
endmodule

// File: rtl/smram_route.sv
module smram_route (
  input  logic in_win_i,
  input  logic enable_i,
  input  logic open_i,
  input  logic closed_i,
  input  logic lock_i,
  input  logic code_i,
  input  logic smm_i,
  output logic dram_o
);
  logic open_eff;

  assign open_eff = open_i && !lock_i;

  always_comb begin
    if (!in_win_i)      dram_o = 1'b1;
    else if (!enable_i) dram_o = 1'b0;
    else if (open_eff)  dram_o = 1'b1;
    else if (!smm_i)    dram_o = 1'b0;
    else if (code_i)    dram_o = 1'b1;
    else                dram_o = !closed_i;
  end
endmodule

// File: rtl/smram_ctrl.sv
module smram_ctrl
  import smram_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                CFG_AW     = 8,
  parameter logic [CFG_AW-1:0] CFG_OFFSET = 8'h72,
  parameter int                WIN_LSB    = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h000A_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  output logic              cfg_err_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_code_i,
  input  logic              acc_smm_i,
  output logic              acc_dram_o
);
  smram_ctl_t ctl;
  logic       in_win;

  smram_cfg_reg #(.CFG_AW(CFG_AW), .CFG_OFFSET(CFG_OFFSET)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .cfg_err_o(cfg_err_o), .ctl_o(ctl)
  );

  smram_win_match #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .WIN_BASE(WIN_BASE)) u_win (
    .addr_i(acc_addr_i), .hit_o(in_win)
  );

  smram_route u_route (
    .in_win_i(in_win), .enable_i(ctl.enable), .open_i(ctl.open_win),
    .closed_i(ctl.closed), .lock_i(ctl.lock), .code_i(acc_code_i),
    .smm_i(acc_smm_i), .dram_o(acc_dram_o)
  );
endmodule

// File: rtl/smram_ctrl_chk.sv
module smram_ctrl_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                CFG_AW     = 8,
  parameter logic [CFG_AW-1:0] CFG_OFFSET = 8'h72
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              cfg_we_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic [7:0]        cfg_wdata_i,
  input logic              cfg_err_o,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_code_i,
  input logic              acc_smm_i,
  input logic              acc_dram_o,
  input logic [7:0]        ctl_q
);
  logic win, wr_hit, bad_wr;

  assign win    = (acc_addr_i >= ADDR_W'(32'h000A_0000)) && (acc_addr_i <= ADDR_W'(32'h000B_FFFF));
  assign wr_hit = cfg_we_i && (cfg_addr_i == CFG_OFFSET) && !soft_rst_i;
  assign bad_wr = wr_hit && !ctl_q[4] && cfg_wdata_i[6] && cfg_wdata_i[5];

  a_r1_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[2:0] == 3'b010) && !ctl_q[7]);
  a_r3_lock_clears_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q[4] && wr_hit) |=> (ctl_q[4] && !ctl_q[6]));
  a_r4_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[4] |=> ctl_q[4]);
  a_r4_soft_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!ctl_q[3] && !ctl_q[6] && !ctl_q[5]));
  a_r5_err_on_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> (cfg_err_o && $stable(ctl_q)));
  a_r5_err_only_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_wr |=> !cfg_err_o);
  a_r5_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_q[6] && ctl_q[5]));
  a_r6_outside_dram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win |-> acc_dram_o);
  a_r7_disabled_pci: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && !ctl_q[3]) |-> !acc_dram_o);
  a_r9_smm_code_dram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && ctl_q[3] && acc_smm_i && acc_code_i) |-> acc_dram_o);
  a_r10_nonsmm_pci: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && ctl_q[3] && !acc_smm_i && (!ctl_q[6] || ctl_q[4])) |-> !acc_dram_o);
endmodule

bind smram_ctrl smram_ctrl_chk #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .CFG_OFFSET(CFG_OFFSET)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .cfg_we_i(cfg_we_i),
  .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_err_o(cfg_err_o),
  .acc_addr_i(acc_addr_i), .acc_code_i(acc_code_i), .acc_smm_i(acc_smm_i),
  .acc_dram_o(acc_dram_o), .ctl_q(ctl)
);

// File: tb/sim_smram_ctrl.sv
module sim_smram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFF = 8'h72;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  caddr = OFF;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        err;
  logic [31:0] aaddr = 32'h0;
  logic        code = 1'b0;
  logic        smm = 1'b0;
  logic        dram;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] m_ctl = 8'h02;
  logic       m_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst), .cfg_we_i(we),
    .cfg_addr_i(caddr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .cfg_err_o(err),
    .acc_addr_i(aaddr), .acc_code_i(code), .acc_smm_i(smm), .acc_dram_o(dram)
  );

  function automatic logic exp_route(logic [7:0] c, logic [31:0] a, logic cd, logic sm);
    if (!(a >= 32'h000A_0000 && a <= 32'h000B_FFFF)) return 1'b1; // R6
    if (!c[3]) return 1'b0;                                         // R7
    if (c[6] && !c[4]) return 1'b1;                                 // R8
    if (!sm) return 1'b0;                                           // R10
    if (cd) return 1'b1;                                            // R9
    return !c[5];
  endfunction

  function automatic logic is_bad(logic [7:0] c, logic [7:0] w);
    return !c[4] && w[6] && w[5];
  endfunction

  function automatic logic [7:0] next_ctl(logic [7:0] c, logic s, logic w, logic [7:0] a, logic [7:0] d);
    logic [7:0] n;
    if (s) return 8'h02 | (c & 8'h10);                 // R4
    if (!(w && a == OFF)) return c;                    // R2
    if (is_bad(c, d)) return c;                        // R5
    n = (d & 8'h78) | 8'h02;
    if (c[4]) n = (n & 8'hBF) | 8'h10;                 // R3
    return n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one cycle: drive at negedge, check comb outputs, take edge, check err
  task automatic cyc(logic s, logic w, logic [7:0] a, logic [7:0] d,
                     logic [31:0] ad, logic cd, logic sm, string req);
    @(negedge clk);
    soft_rst = s; we = w; caddr = a; wdata = d; aaddr = ad; code = cd; smm = sm;
    #1;
    chk({req, " route R11"}, dram, exp_route(m_ctl, ad, cd, sm));
    chk({req, " rdata R1"}, rdata, (a == OFF) ? m_ctl : 8'h00);
    @(posedge clk);
    m_err = !s && w && (a == OFF) && is_bad(m_ctl, d);
    m_ctl = next_ctl(m_ctl, s, w, a, d);
    #1;
    chk({req, " err R5"}, err, m_err);
  endtask

  task automatic wr(logic [7:0] d, string req);
    cyc(1'b0, 1'b1, OFF, d, 32'h000A_1000, 1'b0, 1'b0, req);
  endtask

  task automatic probe(logic [31:0] ad, logic cd, logic sm, logic exp, string req);
    cyc(1'b0, 1'b0, OFF, 8'h00, ad, cd, sm, req);
    chk(req, rdata, m_ctl);
    checks++;
    if (exp_route(m_ctl, ad, cd, sm) !== exp) begin
      errors++;
      $display("FAIL %s model act=%b exp=%b", req, exp_route(m_ctl, ad, cd, sm), exp);
    end
  endtask

  task automatic por();
    @(negedge clk);
    rst_ni = 1'b0; we = 1'b0; soft_rst = 1'b0; caddr = OFF;
    m_ctl = 8'h02; m_err = 1'b0;
    #1;
    chk("R1 reset rdata", rdata, 8'h02);
    chk("R1 reset err", err, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5A17));
    por();
    // R1 other offset reads zero
    cyc(1'b0, 1'b0, 8'h71, 8'h00, 32'h0, 1'b0, 1'b0, "R1 other offset");
    // R6 boundaries, R7 disabled
    probe(32'h0009_FFFF, 1'b0, 1'b1, 1'b1, "R6 below window");
    probe(32'h000A_0000, 1'b0, 1'b1, 1'b0, "R7 window low");
    probe(32'h000B_FFFF, 1'b1, 1'b1, 1'b0, "R7 window high");
    probe(32'h000C_0000, 1'b0, 1'b0, 1'b1, "R6 above window");
    probe(32'h100A_0000, 1'b0, 1'b0, 1'b1, "R6 high bits");
    // R2 other offset write ignored
    cyc(1'b0, 1'b1, 8'h73, 8'h48, 32'h000A_0000, 1'b0, 1'b0, "R2 wrong offset");
    probe(32'h000A_0000, 1'b0, 1'b0, 1'b0, "R2 unchanged");
    // R2/R8 open
    wr(8'hCF, "R2 masking");
    chk("R2 stored", rdata, 8'h4A);
    probe(32'h000A_0000, 1'b0, 1'b0, 1'b1, "R8 data nonsmm");
    probe(32'h000B_0000, 1'b1, 1'b1, 1'b1, "R8 code smm");
    // R5 illegal
    wr(8'h68, "R5 illegal");
    chk("R5 unchanged", rdata, 8'h4A);
    // R9 closed
    wr(8'h28, "R9 setup");
    probe(32'h000A_8000, 1'b1, 1'b1, 1'b1, "R9 code smm");
    probe(32'h000A_8000, 1'b0, 1'b1, 1'b0, "R9 data closed");
    probe(32'h000A_8000, 1'b0, 1'b0, 1'b0, "R10 nonsmm");
    wr(8'h08, "R9 setup2");
    probe(32'h000A_8000, 1'b0, 1'b1, 1'b1, "R9 data open-closed0");
    // R3 lock
    wr(8'h58, "R3 lock set");
    chk("R3 stored", rdata, 8'h5A);
    probe(32'h000A_0000, 1'b0, 1'b0, 1'b0, "R10 open ignored locked");
    wr(8'h68, "R3 locked both");
    chk("R3 forced", rdata, 8'h3A);
    wr(8'h00, "R3 clear try");
    chk("R3 lock kept", rdata, 8'h12);
    // R4 soft reset with write same cycle
    wr(8'h28, "R4 setup");
    cyc(1'b1, 1'b1, OFF, 8'h68, 32'h000A_0000, 1'b0, 1'b1, "R4 soft");
    chk("R4 after soft", rdata, 8'h12);
    por();
    chk("R4 por clears lock", rdata, 8'h02);
    // random phase
    for (int ph = 0; ph < 2; ph++) begin
      for (int i = 0; i < 3000; i++) begin
        logic [31:0] r, ad;
        logic [7:0] d;
        r = $urandom;
        d = 8'($urandom);
        if (ph == 1 && r[9:4] != 0) d[4] = 1'b0;
        ad = (r[3:2] == 2'b00) ? $urandom : (32'h000A_0000 | 32'($urandom % 32'h20000));
        cyc(r[12:0] == 13'h0 ? 1'b0 : (r[20:16] == 5'h1f), r[30:28] == 3'h0,
            r[27] ? OFF : 8'($urandom), d, ad, r[25], r[26], "rand");
      end
      por();
    end
    summary();
  end
endmodule